// File: doc/BRIEF.md
# Configurable Interrupt Trigger Detector

This block conditions the external interrupt lines before they reach the priority controller. Each line belongs to a group, and each group has a 2-bit trigger mode. In the two edge modes, any change of the line raises a request. In the two level modes, a line at 1 raises a request and a line at 0 raises none. The polarity written into the mode does not change either rule.

Software programs the modes through a byte-wide configuration port. Each configuration byte packs the fields of four consecutive groups. The output is a vector of request-set pulses, one bit per line, registered one cycle after the qualifying input condition. Clearing requests and arbitrating between them belong to the controller. The inputs are assumed to be synchronous to `clk` already.

Top module: `irq_trigger_stage`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `req_set_o` is all zeros. After reset every group holds mode code 2'b00 (falling edge), so both configuration bytes read back as 8'h00.
- R2: Byte offset b holds the modes of groups 4b to 4b+3. Group 4b+g occupies bits [2g+1:2g] of that byte. A write takes effect at the next clock edge. `cfg_rdata_o` combinationally shows the byte selected by `cfg_addr_i`. The mode codes are: 2'b00 falling edge, 2'b01 rising edge, 2'b10 low level, 2'b11 high level.
- R3: In mode 2'b00 or 2'b01, a rising or falling change of a line between two clock edges gives a 1 on that line's `req_set_o` bit after the second edge.
- R4: In an edge mode, a line that holds the same value across two edges gives 0 on its `req_set_o` bit after the second edge. A single change therefore yields a pulse exactly one cycle long.
- R5: In mode 2'b10 or 2'b11, the `req_set_o` bit after an edge equals the line value sampled at that edge. The bit is 1 for every cycle the line is 1 and 0 when the line is 0, whichever of the two level codes is set.
- R6: Writing a new mode does not by itself create a request. A line held steady through a switch from a level mode to an edge mode gives no pulse. A line held at 0 through a switch from an edge mode to a level mode gives no pulse.
- R7: A line that is already 1 when reset is released gives no edge pulse. The stage takes the line's value during reset as its reference.
- R8: A group's mode changes only on a write to its own byte offset. A write to one offset leaves the other byte's readback unchanged, and each line follows only its own group's mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_addr_i | input | CFG_ADDR_W (1) | Configuration byte offset |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration byte at `cfg_addr_i` |
| line_i | input | N_LINES (8) | External interrupt lines, already synchronous |
| req_set_o | output | N_LINES (8) | Request-set pulses toward the controller |

## Verification
A wrong reference value on a line shows up within one cycle. It appears either as a spurious pulse on a steady line or as a missing pulse on a changing one. A wrong stored mode shows up at once on `cfg_rdata_o`. At `req_set_o` it shows up at the first cycle where the edge rule and the level rule disagree: a line held at 1, or a line changing from 1 to 0. The stimulus therefore mixes all four codes across groups, so that every line is exercised in those distinguishing cycles.

// File: rtl/irq_trig_pkg.sv
// Shared definitions for the interrupt trigger detector.
// Assumes: mode fields are 2 bits, and four fields share one configuration byte.
package irq_trig_pkg;

    localparam int MODE_W          = 2;
    localparam int CFG_BYTE_W      = 8;
    localparam int FIELDS_PER_BYTE = CFG_BYTE_W / MODE_W;

    // Trigger mode codes; bit 1 selects level sensing.
    typedef enum logic [MODE_W-1:0] {
        TRIG_FALL = 2'b00,
        TRIG_RISE = 2'b01,
        TRIG_LOW  = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_mode_e;

    localparam trig_mode_e TRIG_RESET = TRIG_FALL;

    // True when a mode code senses levels instead of changes.
    function automatic logic mode_is_level(input logic [MODE_W-1:0] m);
        return m[MODE_W-1];
    endfunction

endpackage

// File: rtl/trig_cfg_regs.sv
// Trigger-mode configuration storage.
// Holds one mode field per group. Four fields are packed per byte, and group 4b+g
// sits at bits [2g+1:2g] of byte b. Reads are combinational on the address;
// writes land at the clock edge. Assumes byte offsets beyond the last group are
// unused: writes there are dropped and reads return zero.
module trig_cfg_regs
    import irq_trig_pkg::*;
#(
    parameter int N_GROUPS   = 8,
    parameter int CFG_ADDR_W = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_i,
    input  logic [CFG_ADDR_W-1:0]      addr_i,
    input  logic [CFG_BYTE_W-1:0]      wdata_i,
    output logic [CFG_BYTE_W-1:0]      rdata_o,
    output logic [N_GROUPS*MODE_W-1:0] mode_flat_o
);

    localparam int N_BYTES = (N_GROUPS + FIELDS_PER_BYTE - 1) / FIELDS_PER_BYTE;

    logic [MODE_W-1:0] mode_q [N_GROUPS];

    for (genvar gi = 0; gi < N_GROUPS; gi++) begin : g_field
        localparam int BYTE_IDX = gi / FIELDS_PER_BYTE;
        localparam int SLOT     = gi % FIELDS_PER_BYTE;

        logic hit;
        assign hit = we_i && (addr_i == CFG_ADDR_W'(BYTE_IDX));

        // Load this group's field from its slot of the written byte.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_q[gi] <= TRIG_RESET;
            end else if (hit) begin
                mode_q[gi] <= wdata_i[SLOT*MODE_W +: MODE_W];
            end
        end

        assign mode_flat_o[gi*MODE_W +: MODE_W] = mode_q[gi];
    end

    // Assemble the addressed byte from the fields it contains.
    always_comb begin
        rdata_o = '0;
        for (int g = 0; g < N_GROUPS; g++) begin
            if (addr_i == CFG_ADDR_W'(g / FIELDS_PER_BYTE)) begin
                rdata_o[(g % FIELDS_PER_BYTE)*MODE_W +: MODE_W] = mode_q[g];
            end
        end
    end

    // Elaboration guard: the address must reach every byte.
    if ((1 << CFG_ADDR_W) < N_BYTES) begin : g_bad_addr_w
        initial $error("trig_cfg_regs: CFG_ADDR_W too narrow for %0d bytes", N_BYTES);
    end

endmodule

// File: rtl/trig_line_detect.sv
// Trigger detector for a single line.
// Keeps a registered copy of the line. In an edge mode it flags any difference
// between the line and that copy. In a level mode it flags the line being 1.
// The flag is registered, so it appears one cycle after the condition.
// During reset the copy follows the line, so a line already high at release
// is not mistaken for an edge.
module trig_line_detect
    import irq_trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              req_set_o
);

    logic prev_q;
    logic hit;

    // Qualify the current sample against the selected rule.
    always_comb begin
        if (mode_is_level(mode_i)) begin
            hit = line_i;
        end else begin
            hit = line_i ^ prev_q;
        end
    end

    // Track the line and register the request-set flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= line_i;
            req_set_o <= 1'b0;
        end else begin
            prev_q    <= line_i;
            req_set_o <= hit;
        end
    end

endmodule

// File: rtl/irq_trigger_stage.sv
// Input conditioning stage for external interrupt lines.
// Holds a packed trigger-mode configuration and turns line activity into
// one-cycle request-set pulses for the priority controller.
// Assumes the lines are synchronous to clk and N_LINES is a multiple of LINES_PER_GROUP.
module irq_trigger_stage
    import irq_trig_pkg::*;
#(
    parameter int N_LINES         = 8,
    parameter int LINES_PER_GROUP = 1,
    parameter int CFG_ADDR_W      = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we_i,
    input  logic [CFG_ADDR_W-1:0] cfg_addr_i,
    input  logic [7:0]            cfg_wdata_i,
    output logic [7:0]            cfg_rdata_o,
    input  logic [N_LINES-1:0]    line_i,
    output logic [N_LINES-1:0]    req_set_o
);

    localparam int N_GROUPS = N_LINES / LINES_PER_GROUP;

    logic [N_GROUPS*MODE_W-1:0] mode_flat;

    trig_cfg_regs #(
        .N_GROUPS   (N_GROUPS),
        .CFG_ADDR_W (CFG_ADDR_W)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (cfg_we_i),
        .addr_i      (cfg_addr_i),
        .wdata_i     (cfg_wdata_i),
        .rdata_o     (cfg_rdata_o),
        .mode_flat_o (mode_flat)
    );

    for (genvar li = 0; li < N_LINES; li++) begin : g_line
        localparam int GRP = li / LINES_PER_GROUP;

        trig_line_detect u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .line_i    (line_i[li]),
            .mode_i    (mode_flat[GRP*MODE_W +: MODE_W]),
            .req_set_o (req_set_o[li])
        );
    end

endmodule

// File: rtl/irq_trigger_stage_chk.sv
// Property checker for irq_trigger_stage, attached by bind.
// Assumes it sees the stored modes as the packed vector from the configuration block.
module irq_trigger_stage_chk #(
    parameter int N_LINES         = 8,
    parameter int N_GROUPS        = 8,
    parameter int LINES_PER_GROUP = 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_we_i,
    input logic [N_LINES-1:0]    line_i,
    input logic [N_LINES-1:0]    req_set_o,
    input logic [N_GROUPS*2-1:0] mode_flat
);

    logic was_in_reset;

    // Remember whether the previous edge was a reset edge.
    always_ff @(posedge clk) begin
        was_in_reset <= !rst_n;
        if (was_in_reset) begin
            p_reset_quiet_r1: assert (req_set_o == '0)
                else $error("req_set_o nonzero after a reset edge");
        end
    end

    // R8: stored modes change only on a write strobe.
    p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we_i |=> $stable(mode_flat));

    for (genvar li = 0; li < N_LINES; li++) begin : g_prop
        localparam int GRP = li / LINES_PER_GROUP;

        // R3: a change in an edge mode produces a pulse.
        p_edge_any_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_flat[GRP*2+1] && (line_i[li] != $past(line_i[li]))) |=> req_set_o[li]);

        // R4: a steady line in an edge mode produces nothing.
        p_edge_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_flat[GRP*2+1] && (line_i[li] == $past(line_i[li]))) |=> !req_set_o[li]);

        // R5: in a level mode the pulse follows the sampled line.
        p_level_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
            mode_flat[GRP*2+1] |=> (req_set_o[li] == $past(line_i[li])));
    end

endmodule

bind irq_trigger_stage irq_trigger_stage_chk #(
    .N_LINES         (N_LINES),
    .N_GROUPS        (N_GROUPS),
    .LINES_PER_GROUP (LINES_PER_GROUP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we_i  (cfg_we_i),
    .line_i    (line_i),
    .req_set_o (req_set_o),
    .mode_flat (mode_flat)
);

// File: tb/irq_trigger_stage_test.sv
// Scoreboard bench: the driver predicts each cycle's pulses, the monitor compares them.
module irq_trigger_stage_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [0:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic [7:0] line = '0;
    logic [7:0] req_set;

    always #5 clk = ~clk;

    irq_trigger_stage uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we_i    (cfg_we),
        .cfg_addr_i  (cfg_addr),
        .cfg_wdata_i (cfg_wdata),
        .cfg_rdata_o (cfg_rdata),
        .line_i      (line),
        .req_set_o   (req_set)
    );

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t      sb[$];
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 0;
    logic [1:0] mdl_mode [8];
    logic [7:0] mdl_prev = '0;

    // Monitor: compare the registered output against the oldest prediction.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_cmp++;
            if (req_set !== it.exp) begin
                n_bad++;
                $display("FAIL %s: req_set=%h expected %h", it.tag, req_set, it.exp);
            end
        end
    end

    // Driver: apply one cycle of stimulus and predict the next output.
    task automatic cycle(input logic rst, input logic [7:0] lv, input logic we,
                         input logic a, input logic [7:0] wd, input string tag);
        item_t it;
        @(negedge clk);
        rst_n = rst; line = lv; cfg_we = we; cfg_addr = a; cfg_wdata = wd;
        it.tag = tag;
        for (int i = 0; i < 8; i++) begin
            if (!rst) it.exp[i] = 1'b0;
            else if (mdl_mode[i][1]) it.exp[i] = lv[i];
            else it.exp[i] = lv[i] ^ mdl_prev[i];
        end
        sb.push_back(it);
        mdl_prev = lv;
        if (!rst) begin
            for (int g = 0; g < 8; g++) mdl_mode[g] = 2'b00;
        end else if (we) begin
            for (int g = 0; g < 4; g++) mdl_mode[4*a+g] = wd[2*g +: 2];
        end
    endtask

    // Read a configuration byte and compare it.
    task automatic rd(input logic a, input logic [7:0] exp, input string tag);
        cycle(1'b1, line, 1'b0, a, 8'h00, tag);
        #1;
        n_cmp++;
        if (cfg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: cfg_rdata=%h expected %h", tag, cfg_rdata, exp);
        end
    endtask

    task automatic hold(input int n, input string tag);
        for (int k = 0; k < n; k++) cycle(1'b1, line, 1'b0, 1'b0, 8'h00, tag);
    endtask

    initial begin
        logic [7:0] lf;
        for (int g = 0; g < 8; g++) mdl_mode[g] = 2'b00;

        // R1 / R7: reset with some lines already high.
        for (int k = 0; k < 3; k++) cycle(1'b0, 8'hA5, 1'b0, 1'b0, 8'h00, "R1 reset");
        cycle(1'b1, 8'hA5, 1'b0, 1'b0, 8'h00, "R7 no pulse at release");
        hold(2, "R7 steady after release");
        rd(1'b0, 8'h00, "R1 byte0 default");
        rd(1'b1, 8'h00, "R1 byte1 default");

        // R3 / R4: default falling-edge code reacts to both directions.
        cycle(1'b1, 8'hA4, 1'b0, 1'b0, 8'h00, "R3 falling line0");
        cycle(1'b1, 8'hA6, 1'b0, 1'b0, 8'h00, "R3 rising line1");
        hold(3, "R4 steady edge mode");
        cycle(1'b1, 8'h59, 1'b0, 1'b0, 8'h00, "R3 all toggle");
        cycle(1'b1, 8'h59, 1'b0, 1'b0, 8'h00, "R4 single-cycle pulse");

        // R2: program all four codes into each byte.
        cycle(1'b1, 8'h59, 1'b1, 1'b0, 8'hE4, "R2 write byte0");
        cycle(1'b1, 8'h59, 1'b1, 1'b1, 8'h1B, "R2 write byte1");
        rd(1'b0, 8'hE4, "R2 byte0 readback");
        rd(1'b1, 8'h1B, "R2 byte1 readback");

        // R5: level lines follow the line value, whatever the polarity code.
        cycle(1'b1, 8'hFF, 1'b0, 1'b0, 8'h00, "R5 all high");
        hold(3, "R5 level held high");
        cycle(1'b1, 8'h00, 1'b0, 1'b0, 8'h00, "R5 all low");
        hold(2, "R5 level held low");

        // R3 / R5 / R8: mixed modes under pseudo-random lines.
        lf = 8'h1D;
        for (int k = 0; k < 48; k++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            cycle(1'b1, lf, 1'b0, 1'b0, 8'h00, "R8 mixed modes");
        end

        // R6: level-to-edge switch with steady high lines.
        cycle(1'b1, 8'hFF, 1'b1, 1'b0, 8'hFF, "R6 set byte0 level");
        cycle(1'b1, 8'hFF, 1'b1, 1'b1, 8'hFF, "R6 set byte1 level");
        hold(2, "R5 high level held");
        cycle(1'b1, 8'hFF, 1'b1, 1'b0, 8'h55, "R6 byte0 to rising edge");
        cycle(1'b1, 8'hFF, 1'b1, 1'b1, 8'h00, "R6 byte1 to falling edge");
        hold(3, "R6 no pulse after switch");

        // R6: edge-to-level switch with lines at 0.
        cycle(1'b1, 8'h00, 1'b0, 1'b0, 8'h00, "R3 drop all");
        cycle(1'b1, 8'h00, 1'b1, 1'b0, 8'hAA, "R6 byte0 to low level");
        cycle(1'b1, 8'h00, 1'b1, 1'b1, 8'hFF, "R6 byte1 to high level");
        hold(3, "R6 no pulse at zero");

        // R8: a write to byte1 leaves byte0 intact.
        cycle(1'b1, 8'h00, 1'b1, 1'b1, 8'h27, "R8 write byte1 only");
        rd(1'b0, 8'hAA, "R8 byte0 unchanged");
        rd(1'b1, 8'h27, "R8 byte1 new value");
        cycle(1'b1, 8'hF0, 1'b0, 1'b0, 8'h00, "R8 per-group rules");
        cycle(1'b1, 8'h0F, 1'b0, 1'b0, 8'h00, "R8 per-group rules");
        hold(2, "R8 per-group rules");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule